// File: doc/BRIEF.md
# Compact Multicycle Load/Store Processor Core

This block is a small 32-bit processor core. It runs an instruction set of twenty-two opcodes. Each instruction passes through a fixed sequence of four clock cycles: fetch, decode and execute, memory, and writeback. One memory port serves both instruction fetch and data access. The port carries a byte address, read data that returns in the same cycle, write data and a write strobe. Software sees eighteen 32-bit registers. Sixteen of them are general purpose. One always reads as zero, and one is the program counter. The six compare instructions set or clear a single condition flag, and the conditional branch reads that flag.

Every fetched word is checked for validity before it has any effect. The checks cover the opcode, the register fields the instruction actually uses, the destination, and the address field. A word that fails a check stops the core, raises an illegal-instruction flag, and leaves the program counter pointing at the offending word. A halt instruction stops the core cleanly. A syscall instruction only produces a one-cycle strobe and then execution continues.

Top module: `tiny_ls_core`

## Requirements
- R1: While reset is asserted and right after it is released, the core is running, not halted and not illegal, and it presents byte address 0 with no write. Reset clears every general register and the condition flag.
- R2: An instruction word is split into four fields: bits 31:27 give the opcode, 26:22 give operand A, 21:17 give operand B, and 16:0 give the address or immediate. Each instruction takes exactly four cycles, and the next fetch is made at the previous address plus 4, wrapping within the byte address width.
- R3: Opcodes 2 (add), 3 (sub) and 4 (mul) write the low 32 bits of A op B into register A. Opcode 17 (move) copies register B into register A.
- R4: Opcodes 5 (quot) and 6 (mod) divide register A by register B as signed values, truncating toward zero, and write the quotient or the remainder into A. A zero divisor gives 0. The most negative value divided by -1 gives the dividend as quotient and 0 as remainder.
- R5: Opcodes 7 (and) and 8 (or) write 1 or 0, treating any nonzero value as true. Opcode 10 (not) writes 1 when A is zero and 0 otherwise. Opcode 9 (neg) writes the two's-complement negation of A. These results go into register A.
- R6: Opcodes 11 to 16 (equal, not equal, less, less-or-equal, greater, greater-or-equal) compare A with B as signed values. They set the flag when the relation holds and clear it otherwise, and they write no register.
- R7: Opcode 21 (branch) loads the program counter from the address field when the flag is set. Otherwise execution continues at the next word.
- R8: Opcode 18 (load) copies the memory word at the address field into A. Opcode 19 (store) writes A to that address. Opcode 20 (load immediate) writes the 17-bit field, zero-extended, into A. Only a store asserts the write strobe.
- R9: Register 16 always reads as zero. Register 17 reads as the address of the word after the executing instruction.
- R10: An opcode of 22 to 31 stops the core with illegal set, and the presented address stays on the offending word.
- R11: An instruction is illegal if any of these holds: a register field it uses holds 18 to 31; it writes A and A is 16 or 17; it uses an address field that has bit 16 set or bits 1:0 nonzero. Such an instruction stops the core as in R10. Fields an instruction does not use are ignored, and registers 16 and 17 are legal as read-only operands.
- R12: Opcode 0 (halt) stops the core with illegal clear, and the core then stays stopped. Opcode 1 (syscall) raises the syscall strobe for exactly one cycle and execution continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Byte address for fetch, load or store |
| mem_rdata | input | 32 | Word at mem_addr, valid in the same cycle |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Store strobe |
| running | output | 1 | Core is executing |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Stop was caused by an invalid word |
| syscall_pulse | output | 1 | One-cycle strobe per syscall |

## Verification
The hardest thing to observe from the ports is the state inside the core: the register file and the condition flag. Neither can be read directly. The stimulus makes them visible by building short programs in the bench memory. Operands are loaded from data words, the operation under test is run, and the result register is stored back to memory. The flag is turned into a memory value by a branch that skips over a load immediate. Reading register 17 depends on exactly when the program counter advances, so a move from register 17 is stored and compared against the address of the word after the move.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam int XLEN = 32;
  localparam int OPW  = 5;
  localparam int REGW = 5;
  localparam int FLDW = XLEN - OPW - 2 * REGW;
  localparam logic [REGW-1:0] RIDX_ZERO = 5'd16;
  localparam logic [REGW-1:0] RIDX_LIM  = 5'd18;

  typedef enum logic [OPW-1:0] {
    OP_HALT = 5'd0, OP_SYSCALL, OP_ADD, OP_SUB, OP_MUL, OP_QUOT, OP_MOD,
    OP_AND, OP_OR, OP_NEG, OP_NOT, OP_EQL, OP_NEQ, OP_LT, OP_LE, OP_GT,
    OP_GE, OP_MOVE, OP_LW, OP_SW, OP_LI, OP_BRANCH
  } opc_e;

  typedef enum logic [2:0] {ST_FETCH, ST_EXEC, ST_MEM, ST_WB, ST_STOP} st_e;

  typedef struct packed {
    logic [OPW-1:0]  opc;
    logic [REGW-1:0] ra;
    logic [REGW-1:0] rb;
    logic [FLDW-1:0] fld;
  } insn_t;

  typedef struct packed {
    logic wr_ra;
    logic is_cmp;
    logic is_lw;
    logic is_sw;
    logic is_branch;
    logic is_halt;
    logic is_sys;
    logic valid;
  } ctl_t;

  localparam logic [XLEN-1:0] SMIN = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] ALL1 = {XLEN{1'b1}};

  function automatic logic [XLEN-1:0] sdiv(logic [XLEN-1:0] a, logic [XLEN-1:0] b);
    if (b == '0) return '0;
    if (a == SMIN && b == ALL1) return SMIN;
    return $unsigned($signed(a) / $signed(b));
  endfunction

  function automatic logic [XLEN-1:0] smod(logic [XLEN-1:0] a, logic [XLEN-1:0] b);
    if (b == '0) return '0;
    if (a == SMIN && b == ALL1) return '0;
    return $unsigned($signed(a) % $signed(b));
  endfunction

  function automatic logic scmp(logic [OPW-1:0] op, logic [XLEN-1:0] a, logic [XLEN-1:0] b);
    logic signed [XLEN-1:0] sa;
    logic signed [XLEN-1:0] sb;
    sa = a;
    sb = b;
    case (op)
      OP_EQL:  return sa == sb;
      OP_NEQ:  return sa != sb;
      OP_LT:   return sa <  sb;
      OP_LE:   return sa <= sb;
      OP_GT:   return sa >  sb;
      OP_GE:   return sa >= sb;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tlc_decode.sv
module tlc_decode
  import tlc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [XLEN-1:0] ir,
  output ctl_t            ctl,
  output logic            bad_opc,
  output logic            bad_reg,
  output logic            bad_dst,
  output logic            bad_addr
);
  insn_t f;
  assign f = ir;

  always_comb begin
    logic use_ra;
    logic use_rb;
    logic use_addr;
    use_ra   = 1'b0;
    use_rb   = 1'b0;
    use_addr = 1'b0;
    ctl      = '0;
    case (f.opc)
      OP_HALT:    ctl.is_halt = 1'b1;
      OP_SYSCALL: ctl.is_sys = 1'b1;
      OP_ADD, OP_SUB, OP_MUL, OP_QUOT, OP_MOD, OP_AND, OP_OR, OP_MOVE: begin
        use_ra = 1'b1; use_rb = 1'b1; ctl.wr_ra = 1'b1;
      end
      OP_NEG, OP_NOT: begin
        use_ra = 1'b1; ctl.wr_ra = 1'b1;
      end
      OP_EQL, OP_NEQ, OP_LT, OP_LE, OP_GT, OP_GE: begin
        use_ra = 1'b1; use_rb = 1'b1; ctl.is_cmp = 1'b1;
      end
      OP_LW: begin
        use_ra = 1'b1; use_addr = 1'b1; ctl.wr_ra = 1'b1; ctl.is_lw = 1'b1;
      end
      OP_SW: begin
        use_ra = 1'b1; use_addr = 1'b1; ctl.is_sw = 1'b1;
      end
      OP_LI: begin
        use_ra = 1'b1; ctl.wr_ra = 1'b1;
      end
      OP_BRANCH: begin
        use_addr = 1'b1; ctl.is_branch = 1'b1;
      end
      default: ;
    endcase
    bad_opc  = f.opc > OP_BRANCH;
    bad_reg  = (use_ra && f.ra >= RIDX_LIM) || (use_rb && f.rb >= RIDX_LIM);
    bad_dst  = ctl.wr_ra && f.ra >= RIDX_ZERO;
    bad_addr = use_addr && (((f.fld >> AW) != '0) || (f.fld[1:0] != 2'b00));
    ctl.valid = !(bad_opc || bad_reg || bad_dst || bad_addr);
  end
endmodule

// File: rtl/tlc_alu.sv
module tlc_alu
  import tlc_pkg::*;
(
  input  logic [OPW-1:0]  op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [FLDW-1:0] imm,
  output logic [XLEN-1:0] res,
  output logic            cmp_true
);
  always_comb begin
    case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_MUL:  res = a * b;
      OP_QUOT: res = sdiv(a, b);
      OP_MOD:  res = smod(a, b);
      OP_AND:  res = XLEN'((a != '0) && (b != '0));
      OP_OR:   res = XLEN'((a != '0) || (b != '0));
      OP_NEG:  res = '0 - a;
      OP_NOT:  res = XLEN'(a == '0);
      OP_MOVE: res = b;
      OP_LI:   res = XLEN'(imm);
      default: res = a;
    endcase
    cmp_true = scmp(op, a, b);
  end
endmodule

// File: rtl/tlc_regfile.sv
module tlc_regfile
  import tlc_pkg::*;
#(
  parameter int NGP = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [REGW-1:0] wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic [REGW-1:0] ra_idx,
  input  logic [REGW-1:0] rb_idx,
  input  logic [XLEN-1:0] link_val,
  output logic [XLEN-1:0] ra_data,
  output logic [XLEN-1:0] rb_data
);
  localparam int IW = $clog2(NGP);
  localparam logic [REGW-1:0] GP_LIM = REGW'(NGP);

  logic [NGP-1:0][XLEN-1:0] flat;

  for (genvar g = 0; g < NGP; g++) begin : g_reg
    logic [XLEN-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (wr_en && wr_idx == REGW'(g)) q <= wr_data;
    end
    assign flat[g] = q;
  end

  assign ra_data = (ra_idx < GP_LIM) ? flat[ra_idx[IW-1:0]] :
                   (ra_idx == GP_LIM) ? '0 : link_val;
  assign rb_data = (rb_idx < GP_LIM) ? flat[rb_idx[IW-1:0]] :
                   (rb_idx == GP_LIM) ? '0 : link_val;

  assert_dst_general_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_idx < GP_LIM);
endmodule

// File: rtl/tiny_ls_core.sv
module tiny_ls_core
  import tlc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [AW-1:0]   mem_addr,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_we,
  output logic            running,
  output logic            halted,
  output logic            illegal,
  output logic            syscall_pulse
);
  st_e             st;
  logic [AW-1:0]   pc;
  logic [AW-1:0]   pc_seq;
  logic [XLEN-1:0] ir;
  logic [XLEN-1:0] res;
  logic            flag;
  logic            ill_q;
  logic            sys_q;
  insn_t           f;
  ctl_t            ctl;
  logic            bad_opc, bad_reg, bad_dst, bad_addr;
  logic [XLEN-1:0] ra_data, rb_data, alu_res;
  logic            cmp_true;
  logic            branch_taken;
  logic            ev_trap;
  logic            ev_retire;

  assign f            = ir;
  assign pc_seq       = pc + AW'(4);
  assign branch_taken = ctl.is_branch && flag;
  assign ev_trap      = (st == ST_EXEC) && !ctl.valid;
  assign ev_retire    = (st == ST_WB);

  tlc_decode #(.AW(AW)) u_dec (
    .ir(ir), .ctl(ctl), .bad_opc(bad_opc), .bad_reg(bad_reg),
    .bad_dst(bad_dst), .bad_addr(bad_addr)
  );

  tlc_regfile #(.NGP(16)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(ev_retire && ctl.wr_ra),
    .wr_idx(f.ra), .wr_data(res), .ra_idx(f.ra), .rb_idx(f.rb),
    .link_val(XLEN'(pc_seq)), .ra_data(ra_data), .rb_data(rb_data)
  );

  tlc_alu u_alu (
    .op(f.opc), .a(ra_data), .b(rb_data), .imm(f.fld),
    .res(alu_res), .cmp_true(cmp_true)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_FETCH;
      pc    <= '0;
      ir    <= '0;
      res   <= '0;
      flag  <= 1'b0;
      ill_q <= 1'b0;
      sys_q <= 1'b0;
    end else begin
      sys_q <= 1'b0;
      case (st)
        ST_FETCH: begin
          ir <= mem_rdata;
          st <= ST_EXEC;
        end
        ST_EXEC: begin
          if (!ctl.valid) begin
            st    <= ST_STOP;
            ill_q <= 1'b1;
          end else if (ctl.is_halt) begin
            st <= ST_STOP;
          end else begin
            res   <= alu_res;
            sys_q <= ctl.is_sys;
            if (ctl.is_cmp) flag <= cmp_true;
            st <= ST_MEM;
          end
        end
        ST_MEM: begin
          if (ctl.is_lw) res <= mem_rdata;
          st <= ST_WB;
        end
        ST_WB: begin
          pc <= branch_taken ? f.fld[AW-1:0] : pc_seq;
          st <= ST_FETCH;
        end
        default: ;
      endcase
    end
  end

  assign mem_addr      = (st == ST_MEM) ? f.fld[AW-1:0] : pc;
  assign mem_we        = (st == ST_MEM) && ctl.is_sw;
  assign mem_wdata     = ra_data;
  assign running       = (st != ST_STOP);
  assign halted        = (st == ST_STOP);
  assign illegal       = ill_q;
  assign syscall_pulse = sys_q;

  assert_trap_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trap |=> (halted && illegal && $stable(mem_addr)));
  assert_badopc_traps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_EXEC) && bad_opc) |=> illegal);
  assert_field_traps_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_EXEC) && (bad_reg || bad_dst || bad_addr)) |=> illegal);
  assert_fetch_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FETCH) |-> (mem_addr[1:0] == 2'b00));
  assert_seq_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_retire && !branch_taken) |=> (mem_addr == $past(mem_addr) + AW'(4)));
  assert_branch_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_retire && branch_taken) |=> (mem_addr == $past(f.fld[AW-1:0])));
  assert_store_only_sw_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((st == ST_MEM) && (f.opc == OP_SW)));
  assert_sys_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    syscall_pulse |=> !syscall_pulse);
  assert_stop_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(illegal)));
endmodule

// File: tb/tiny_ls_core_bench.sv
`timescale 1ns/1ps
module tiny_ls_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [31:0] mem_rdata, mem_wdata;
  logic        mem_we, running, halted, illegal, syscall_pulse;
  logic        ld_we = 1'b0;
  logic [9:0]  ld_a = '0;
  logic [31:0] ld_d = '0;
  logic [31:0] mem [1024];
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  tiny_ls_core u_tiny_ls_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .running(running),
    .halted(halted), .illegal(illegal), .syscall_pulse(syscall_pulse)
  );

  always @(posedge clk) begin
    if (ld_we) mem[ld_a] <= ld_d;
    else if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
  end
  assign mem_rdata = mem[mem_addr[11:2]];

  typedef struct packed {
    logic [4:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        flg;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VTAB [NV] = '{
    '{5'd2,  32'd5,        32'd7,        32'd12,       1'b0},
    '{5'd2,  32'hFFFFFFFF, 32'd2,        32'd1,        1'b0},
    '{5'd3,  32'd3,        32'd5,        32'hFFFFFFFE, 1'b0},
    '{5'd4,  32'h00010000, 32'h00010000, 32'd0,        1'b0},
    '{5'd4,  32'd7,        32'hFFFFFFFD, 32'hFFFFFFEB, 1'b0},
    '{5'd5,  32'hFFFFFFF9, 32'd2,        32'hFFFFFFFD, 1'b0},
    '{5'd5,  32'd9,        32'd0,        32'd0,        1'b0},
    '{5'd5,  32'h80000000, 32'hFFFFFFFF, 32'h80000000, 1'b0},
    '{5'd6,  32'hFFFFFFF9, 32'd2,        32'hFFFFFFFF, 1'b0},
    '{5'd6,  32'd9,        32'd0,        32'd0,        1'b0},
    '{5'd7,  32'd5,        32'd0,        32'd0,        1'b0},
    '{5'd7,  32'd5,        32'hFFFFFFFF, 32'd1,        1'b0},
    '{5'd8,  32'd0,        32'd0,        32'd0,        1'b0},
    '{5'd8,  32'd0,        32'd8,        32'd1,        1'b0},
    '{5'd9,  32'd5,        32'd0,        32'hFFFFFFFB, 1'b0},
    '{5'd10, 32'd0,        32'd0,        32'd1,        1'b0},
    '{5'd10, 32'd7,        32'd0,        32'd0,        1'b0},
    '{5'd11, 32'd4,        32'd4,        32'd4,        1'b1},
    '{5'd12, 32'd1,        32'd2,        32'd1,        1'b1},
    '{5'd13, 32'hFFFFFFFF, 32'd1,        32'hFFFFFFFF, 1'b1},
    '{5'd14, 32'd5,        32'd3,        32'd5,        1'b0},
    '{5'd15, 32'hFFFFFFFF, 32'd1,        32'hFFFFFFFF, 1'b0},
    '{5'd16, 32'd3,        32'd3,        32'd3,        1'b1},
    '{5'd17, 32'd9,        32'h55,       32'h55,       1'b0}
  };

  function automatic logic [31:0] enc(int op, int r1, int r2, int fld);
    return {5'(op), 5'(r1), 5'(r2), 17'(fld)};
  endfunction

  function automatic string tag_of(logic [4:0] op);
    if (op <= 5'd4 || op == 5'd17) return "R3";
    if (op <= 5'd6) return "R4";
    if (op <= 5'd10) return "R5";
    return "R6";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [31:0] d);
    @(negedge clk);
    ld_we = 1'b1;
    ld_a  = 10'(a >> 2);
    ld_d  = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic run_prog(output int sysn);
    int cyc;
    cyc  = 0;
    sysn = 0;
    @(negedge clk);
    rst_n = 1'b1;
    while (!halted && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (syscall_pulse) sysn++;
    end
  endtask

  task automatic stop_run();
    @(negedge clk);
    rst_n = 1'b0;
  endtask

  task automatic trap_one(input string tag, input logic [31:0] w);
    int s;
    put(0, w);
    run_prog(s);
    chk(tag, {31'b0, illegal}, 32'd1);
    chk(tag, {16'b0, mem_addr}, 32'd0);
    stop_run();
  endtask

  initial begin
    #(20ns * 150000);
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  initial begin
    int s;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    chk("R1", {31'b0, running}, 32'd1);
    chk("R1", {31'b0, halted}, 32'd0);
    chk("R1", {31'b0, illegal}, 32'd0);
    chk("R1", {16'b0, mem_addr}, 32'd0);
    chk("R1", {31'b0, mem_we}, 32'd0);

    // vector table: lw/lw/op/sw, then flag captured by a branch
    for (int i = 0; i < NV; i++) begin
      put(0,  enc(18, 1, 0, 'h200));
      put(4,  enc(18, 2, 0, 'h204));
      put(8,  enc(VTAB[i].op, 1, 2, 0));
      put(12, enc(19, 1, 0, 'h208));
      put(16, enc(20, 4, 0, 1));
      put(20, enc(21, 0, 0, 28));
      put(24, enc(20, 4, 0, 0));
      put(28, enc(19, 4, 0, 'h20C));
      put(32, enc(0, 0, 0, 0));
      put('h200, VTAB[i].a);
      put('h204, VTAB[i].b);
      put('h208, 32'hDEADBEEF);
      put('h20C, 32'hDEADBEEF);
      run_prog(s);
      chk(tag_of(VTAB[i].op), mem['h208 >> 2], VTAB[i].res);
      chk(VTAB[i].flg ? "R7" : "R7", mem['h20C >> 2], {31'b0, VTAB[i].flg});
      stop_run();
    end

    // R1: reset clears registers and flag after a run that set them
    put(0, enc(20, 5, 0, 'h1234));
    put(4, enc(11, 0, 0, 0));
    put(8, enc(0, 0, 0, 0));
    run_prog(s);
    stop_run();
    put(0,  enc(19, 5, 0, 'h300));
    put(4,  enc(21, 0, 0, 16));
    put(8,  enc(20, 1, 0, 1));
    put(12, enc(19, 1, 0, 'h304));
    put(16, enc(0, 0, 0, 0));
    put('h300, 32'hDEADBEEF);
    put('h304, 32'hDEADBEEF);
    run_prog(s);
    chk("R1", mem['h300 >> 2], 32'd0);
    chk("R1", mem['h304 >> 2], 32'd1);
    stop_run();

    // R2: four cycles per instruction, field used as address in memory phase
    put(0, enc(20, 1, 0, 5));
    put(4, enc(0, 0, 0, 0));
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2", {16'b0, mem_addr}, 32'd5);
    repeat (2) @(negedge clk);
    chk("R2", {16'b0, mem_addr}, 32'd4);
    @(negedge clk);
    chk("R2", {31'b0, halted}, 32'd0);
    @(negedge clk);
    chk("R12", {31'b0, halted}, 32'd1);
    chk("R12", {31'b0, illegal}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R12", {31'b0, halted}, 32'd1);
    stop_run();

    // R9: zero register and program counter register reads
    put(0,  enc(20, 1, 0, 7));
    put(4,  enc(17, 1, 16, 0));
    put(8,  enc(17, 2, 17, 0));
    put(12, enc(19, 1, 0, 'h300));
    put(16, enc(19, 2, 0, 'h304));
    put(20, enc(0, 0, 0, 0));
    run_prog(s);
    chk("R9", mem['h300 >> 2], 32'd0);
    chk("R9", mem['h304 >> 2], 32'd12);
    stop_run();

    // R10: invalid opcodes stop on the offending word
    put(0, enc(20, 1, 0, 1));
    put(4, enc(22, 0, 0, 0));
    run_prog(s);
    chk("R10", {31'b0, illegal}, 32'd1);
    chk("R10", {31'b0, halted}, 32'd1);
    chk("R10", {16'b0, mem_addr}, 32'd4);
    stop_run();
    trap_one("R10", enc(31, 0, 0, 0));

    // R11: field validity
    trap_one("R11", enc(2, 18, 1, 0));
    trap_one("R11", enc(2, 1, 20, 0));
    trap_one("R11", enc(20, 16, 0, 5));
    trap_one("R11", enc(17, 17, 1, 0));
    trap_one("R11", enc(18, 1, 0, 'h202));
    trap_one("R11", enc(19, 1, 0, 'h10000));
    trap_one("R11", enc(21, 0, 0, 6));

    // R11/R8: unused fields ignored, read-only R17, 17-bit immediate
    put(0,  enc(19, 17, 0, 'h300));
    put(4,  enc(20, 1, 0, 5));
    put(8,  enc(9, 1, 31, 'h1FFFF));
    put(12, enc(19, 1, 0, 'h304));
    put(16, enc(20, 2, 0, 'h1FFFF));
    put(20, enc(19, 2, 0, 'h308));
    put(24, 32'h07FFFFFF);
    run_prog(s);
    chk("R11", {31'b0, illegal}, 32'd0);
    chk("R11", mem['h300 >> 2], 32'd4);
    chk("R11", mem['h304 >> 2], 32'hFFFFFFFB);
    chk("R8", mem['h308 >> 2], 32'h0001FFFF);
    stop_run();

    // R12: syscall strobe then continue
    put(0,  enc(1, 31, 31, 'h1FFFF));
    put(4,  enc(20, 1, 0, 3));
    put(8,  enc(19, 1, 0, 'h300));
    put(12, enc(0, 0, 0, 0));
    run_prog(s);
    chk("R12", 32'(s), 32'd1);
    chk("R12", mem['h300 >> 2], 32'd3);
    stop_run();

    // R7: taken branch to a distant address
    put(0,    enc(11, 0, 0, 0));
    put(4,    enc(21, 0, 0, 'h40));
    put(8,    enc(22, 0, 0, 0));
    put('h40, enc(20, 1, 0, 9));
    put('h44, enc(19, 1, 0, 'h300));
    put('h48, enc(0, 0, 0, 0));
    run_prog(s);
    chk("R7", {31'b0, illegal}, 32'd0);
    chk("R7", mem['h300 >> 2], 32'd9);
    stop_run();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule